// File: doc/BRIEF.md
# UART Receive Buffer with Watermark and Error Flags

This block sits behind a UART receiver front end and holds the characters it completes. Each finished character arrives as a one-cycle strobe, once its stop bit is done, together with its data bits and three error indications: noise, framing and parity. The block stores them in a small first-in first-out buffer. A mode input turns that buffer into a single-entry holding register.

Software takes words from the head of the buffer with a read strobe. It watches a data-ready flag, which in buffered mode compares the stored word count against a programmable watermark. Noise, framing and parity flags always describe the word that the next read will return. An overrun flag records a word that arrived when no room was left. While that flag is set, storage is frozen. The overrun flag and the three error flags are cleared by writing a one to them.

A character still being shifted in has no effect here: only the completion strobe changes buffer state. A new completion is accepted even while data-ready is high.

Top module: `rxbuf_status`

## Requirements
- R1: With `fifo_en` high, `data_ready` is high exactly when the stored word count is greater than `watermark`. A word offered on `char_valid` is counted from the cycle after the strobe.
- R2: With `fifo_en` low, the buffer holds one word. `data_ready` is high while that word is held and `watermark` has no effect. A second word arriving before the read causes an overrun.
- R3: Words are returned in arrival order. `rd_data` shows the head word, a `rd_stb` removes it, and `rd_data` reads 0 while the buffer is empty.
- R4: A word arriving when the buffer is full sets `overrun` on the next cycle and is discarded. The stored words and their error flags are unchanged.
- R5: While `overrun` is high, no arriving word is stored, even when the buffer has free space.
- R6: `err_noise`, `err_frame` and `err_parity` show the noise, framing and parity bits stored with the head word. They read 0 when the buffer is empty.
- R7: Writing 1 to `clr_overrun` clears `overrun`; a new overrun in the same cycle wins. Writing 1 to `clr_noise`, `clr_frame` or `clr_parity` clears that bit of the head word only.
- R8: A `rd_stb` while the buffer is empty is ignored and changes no state.
- R9: A word arriving in the same cycle as a read of a full buffer is stored, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1: multi-entry buffer, 0: single entry |
| watermark | input | CW | Data-ready threshold, used in buffered mode |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | DW | Data bits of the completed character |
| char_noise | input | 1 | Noise seen in the completed character |
| char_frame | input | 1 | Stop bit was sampled low |
| char_parity | input | 1 | Parity mismatch in the completed character |
| rd_stb | input | 1 | Pops the head word |
| clr_overrun | input | 1 | Write-one-to-clear for overrun |
| clr_noise | input | 1 | Write-one-to-clear for the head noise bit |
| clr_frame | input | 1 | Write-one-to-clear for the head framing bit |
| clr_parity | input | 1 | Write-one-to-clear for the head parity bit |
| rd_data | output | DW | Head word, 0 when empty |
| data_ready | output | 1 | Data-ready flag |
| overrun | output | 1 | Sticky overrun flag |
| err_noise | output | 1 | Noise bit of the head word |
| err_frame | output | 1 | Framing bit of the head word |
| err_parity | output | 1 | Parity bit of the head word |

## Verification
The hardest state to reach is a full buffer that meets an arriving word. Whether that word is stored or lost depends on whether a read lands in the same cycle and on whether overrun is already set. The bench fills the buffer to exactly its depth and then presents the arrival three ways: alone, together with a read, and after overrun with a slot freed. It then drains the buffer and compares every word and its error bits against the list it expects. The watermark comparison is swept over every pair of fill level and threshold.

// File: rtl/rxbuf_pkg.sv
// Shared types for the receive buffer.
// Assumes: error bits are always handled as a group of three.
package rxbuf_pkg;
    // Error indications kept with each stored word.
    typedef struct packed {
        logic noise;
        logic frame;
        logic parity;
    } rx_err_t;
endpackage

// File: rtl/rxbuf_store.sv
// Word storage for the receive buffer: a circular array of DEPTH entries,
// each holding its data bits and three error bits.
// Assumes: push and pop are already qualified by the control logic (no push
// into a full array unless a pop happens in the same cycle, no pop when empty).
module rxbuf_store
    import rxbuf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  rx_err_t       push_err,
    input  logic          pop,
    input  rx_err_t       err_clr,
    output logic [DW-1:0] head_data,
    output rx_err_t       head_err,
    output logic [CW-1:0] count
);

    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [DEPTH-1:0][DW-1:0] data_flat;
    rx_err_t [DEPTH-1:0]      err_flat;
    logic                     not_empty;

    assign not_empty = (count != '0);

    // Step a pointer around the ring.
    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance read and write pointers and track the word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] d_q;
        rx_err_t       e_q;

        // Load the entry on a push, or clear error bits of the held head word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                e_q <= '0;
            end else if (push && (wr_ptr == PW'(i))) begin
                d_q <= push_data;
                e_q <= push_err;
            end else if (not_empty && (rd_ptr == PW'(i))) begin
                e_q <= rx_err_t'(e_q & ~err_clr);
            end
        end

        assign data_flat[i] = d_q;
        assign err_flat[i]  = e_q;
    end

    // Present the head entry, or zeros when nothing is held.
    always_comb begin
        head_data = not_empty ? data_flat[rd_ptr] : '0;
        head_err  = not_empty ? err_flat[rd_ptr]  : '0;
    end

endmodule

// File: rtl/rxbuf_ctrl.sv
// Admission and flag control for the receive buffer: decides whether an
// arriving word is stored, raises and clears overrun, qualifies reads and
// forms the data-ready flag.
// Assumes: char_valid is a one-cycle strobe per completed character;
// fifo_en is changed only while the buffer is empty.
module rxbuf_ctrl #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] watermark,
    input  logic          char_valid,
    input  logic          rd_stb,
    input  logic          clr_overrun,
    input  logic [CW-1:0] count,
    output logic          push,
    output logic          pop,
    output logic          overrun,
    output logic          data_ready
);

    logic [CW-1:0] capacity;
    logic [CW-1:0] after_pop;
    logic          room;
    logic          lose_word;

    // Work out whether the arriving word fits after this cycle's read.
    always_comb begin
        capacity  = fifo_en ? CW'(DEPTH) : CW'(1);
        pop       = rd_stb && (count != '0);
        after_pop = count - CW'(pop);
        room      = (after_pop < capacity);
        push      = char_valid && !overrun && room;
        lose_word = char_valid && !overrun && !room;
    end

    // Sticky overrun: a new loss takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           overrun <= 1'b0;
        else if (lose_word)   overrun <= 1'b1;
        else if (clr_overrun) overrun <= 1'b0;
    end

    // Data-ready against the watermark, or single-entry full.
    always_comb begin
        data_ready = fifo_en ? (count > watermark) : (count != '0);
    end

endmodule

// File: rtl/rxbuf_status.sv
// Receive buffer with watermark data-ready, sticky overrun and per-word
// error flags for a UART receiver.
// Assumes: the receiver front end pulses char_valid once per character after
// its stop bit; software issues rd_stb and write-one clears as single pulses.
module rxbuf_status
    import rxbuf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] watermark,
    input  logic          char_valid,
    input  logic [DW-1:0] char_data,
    input  logic          char_noise,
    input  logic          char_frame,
    input  logic          char_parity,
    input  logic          rd_stb,
    input  logic          clr_overrun,
    input  logic          clr_noise,
    input  logic          clr_frame,
    input  logic          clr_parity,
    output logic [DW-1:0] rd_data,
    output logic          data_ready,
    output logic          overrun,
    output logic          err_noise,
    output logic          err_frame,
    output logic          err_parity
);

    logic          push;
    logic          pop;
    logic [CW-1:0] count;
    rx_err_t       in_err;
    rx_err_t       clr_mask;
    rx_err_t       head_err;

    // Group the per-character indications and the clear strobes.
    always_comb begin
        in_err.noise    = char_noise;
        in_err.frame    = char_frame;
        in_err.parity   = char_parity;
        clr_mask.noise  = clr_noise;
        clr_mask.frame  = clr_frame;
        clr_mask.parity = clr_parity;
    end

    rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (fifo_en),
        .watermark   (watermark),
        .char_valid  (char_valid),
        .rd_stb      (rd_stb),
        .clr_overrun (clr_overrun),
        .count       (count),
        .push        (push),
        .pop         (pop),
        .overrun     (overrun),
        .data_ready  (data_ready)
    );

    rxbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (char_data),
        .push_err  (in_err),
        .pop       (pop),
        .err_clr   (clr_mask),
        .head_data (rd_data),
        .head_err  (head_err),
        .count     (count)
    );

    // Expose the head word's error bits.
    always_comb begin
        err_noise  = head_err.noise;
        err_frame  = head_err.frame;
        err_parity = head_err.parity;
    end

endmodule

// File: rtl/rxbuf_status_chk.sv
// Assertion checker for rxbuf_status, attached by bind.
// Assumes: same parameters as the instance it is bound to.
module rxbuf_status_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          char_valid,
    input logic          rd_stb,
    input logic          clr_overrun,
    input logic          clr_noise,
    input logic [DW-1:0] rd_data,
    input logic          data_ready,
    input logic          overrun,
    input logic          err_noise,
    input logic          err_frame,
    input logic          err_parity,
    input logic [CW-1:0] count
);

    // R7: overrun stays set until written with a one.
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_overrun) |=> overrun);

    // R4: while overrun holds and nothing is read, the head word does not move.
    a_r4_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_stb) |=> $stable(rd_data));

    // R5: under overrun, an arrival without a read never grows the count.
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && char_valid && !rd_stb) |=> $stable(count));

    // R6: single-entry mode with nothing ready shows no error flags.
    a_r6_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !data_ready) |-> !(err_noise || err_frame || err_parity));

    // R7: clearing the noise bit of a held head word takes effect next cycle.
    a_r7_noise_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_noise && !rd_stb && (count != '0)) |=> !err_noise);

    // R8: a read of an empty buffer with no arrival leaves it empty.
    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '0) && rd_stb && !char_valid) |=> (count == '0));

    // R2: a held single word stays ready until it is read.
    a_r2_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && data_ready && !rd_stb) |=> data_ready);

    // R1: the count never exceeds the buffer depth.
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

bind rxbuf_status rxbuf_status_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .char_valid  (char_valid),
    .rd_stb      (rd_stb),
    .clr_overrun (clr_overrun),
    .clr_noise   (clr_noise),
    .rd_data     (rd_data),
    .data_ready  (data_ready),
    .overrun     (overrun),
    .err_noise   (err_noise),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .count       (count)
);

// File: tb/tb_rxbuf_status.sv
module tb_rxbuf_status;
    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1;
    logic [CW-1:0] watermark = '0;
    logic char_valid = 1'b0;
    logic [DW-1:0] char_data = '0;
    logic char_noise = 1'b0, char_frame = 1'b0, char_parity = 1'b0;
    logic rd_stb = 1'b0;
    logic clr_overrun = 1'b0, clr_noise = 1'b0, clr_frame = 1'b0, clr_parity = 1'b0;
    logic [DW-1:0] rd_data;
    logic data_ready, overrun, err_noise, err_frame, err_parity;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rxbuf_status #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .watermark(watermark),
        .char_valid(char_valid), .char_data(char_data),
        .char_noise(char_noise), .char_frame(char_frame), .char_parity(char_parity),
        .rd_stb(rd_stb), .clr_overrun(clr_overrun), .clr_noise(clr_noise),
        .clr_frame(clr_frame), .clr_parity(clr_parity),
        .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
        .err_noise(err_noise), .err_frame(err_frame), .err_parity(err_parity)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; clr bits are {overrun, noise, frame, parity}.
    task automatic step(input bit cv, input logic [DW-1:0] d, input logic [2:0] e,
                        input bit rd, input logic [3:0] clr);
        char_valid = cv; char_data = d;
        {char_noise, char_frame, char_parity} = e;
        rd_stb = rd;
        {clr_overrun, clr_noise, clr_frame, clr_parity} = clr;
        @(negedge clk);
        char_valid = 1'b0; rd_stb = 1'b0;
        {clr_overrun, clr_noise, clr_frame, clr_parity} = 4'b0;
    endtask

    task automatic push(input logic [DW-1:0] d, input logic [2:0] e);
        step(1'b1, d, e, 1'b0, 4'b0);
    endtask

    // Compare the head word and its flags, then pop it.
    task automatic pop_expect(input logic [DW-1:0] d, input logic [2:0] e, input string req);
        check(rd_data == d, req, rd_data, d);
        check({err_noise, err_frame, err_parity} == e, req,
              {err_noise, err_frame, err_parity}, e);
        step(1'b0, '0, 3'b0, 1'b1, 4'b0);
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0; fifo_en = mode;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        // Reset state (R3, R6)
        check(!data_ready && !overrun, "R1 reset flags", {data_ready, overrun}, 0);
        check(rd_data == 0, "R3 empty data", rd_data, 0);
        check({err_noise, err_frame, err_parity} == 0, "R6 empty flags",
              {err_noise, err_frame, err_parity}, 0);

        // R1 and R3: every fill level against every watermark, then drain in order.
        for (int wm = 0; wm <= DEPTH; wm++) begin
            for (int k = 0; k <= DEPTH; k++) begin
                do_reset(1'b1);
                watermark = CW'(wm);
                for (int j = 0; j < k; j++) push(DW'(8'h10 + j), 3'b0);
                check(data_ready == (k > wm), "R1 watermark", data_ready, (k > wm));
                for (int j = 0; j < k; j++) begin
                    pop_expect(DW'(8'h10 + j), 3'b0, "R3 order");
                    check(data_ready == ((k - j - 1) > wm), "R1 drain",
                          data_ready, ((k - j - 1) > wm));
                end
                check(rd_data == 0, "R3 drained", rd_data, 0);
            end
        end

        // R6: each error code travels with its word.
        do_reset(1'b1);
        for (int c = 0; c < 8; c++) begin
            push(DW'(8'h40 + c), 3'(c));
            if (c % DEPTH == DEPTH - 1)
                for (int j = c - DEPTH + 1; j <= c; j++)
                    pop_expect(DW'(8'h40 + j), 3'(j), "R6 head flags");
        end

        // R2: single-entry mode ignores the watermark and overruns on a second word.
        for (int wm = 0; wm <= DEPTH; wm++) begin
            do_reset(1'b0);
            watermark = CW'(wm);
            check(!data_ready, "R2 empty", data_ready, 0);
            push(8'hA5, 3'b010);
            check(data_ready, "R2 ready", data_ready, 1);
            push(8'h5A, 3'b101);
            check(overrun, "R2 second word overruns", overrun, 1);
            pop_expect(8'hA5, 3'b010, "R2 kept word");
            check(!data_ready, "R2 cleared by read", data_ready, 0);
            // R5: still under overrun, nothing stored.
            push(8'h77, 3'b0);
            check(!data_ready && rd_data == 0, "R5 single frozen", rd_data, 0);
            step(1'b0, '0, 3'b0, 1'b0, 4'b1000);
            check(!overrun, "R7 overrun clear", overrun, 0);
            push(8'h66, 3'b0);
            pop_expect(8'h66, 3'b0, "R5 storage resumes");
        end

        // R4, R5: overrun in buffered mode.
        do_reset(1'b1);
        watermark = '0;
        for (int j = 0; j < DEPTH; j++) push(DW'(8'h20 + j), 3'(j));
        check(!overrun, "R4 full no overrun", overrun, 0);
        push(8'hFF, 3'b111);
        check(overrun, "R4 overrun set", overrun, 1);
        pop_expect(8'h20, 3'd0, "R4 head intact");
        push(8'hEE, 3'b111);
        for (int j = 1; j < DEPTH; j++) pop_expect(DW'(8'h20 + j), 3'(j), "R5 no store");
        check(!data_ready && rd_data == 0, "R5 nothing extra", rd_data, 0);

        // R7: write-one clears and set-over-clear priority.
        do_reset(1'b1);
        push(8'h31, 3'b111);
        step(1'b0, '0, 3'b0, 1'b0, 4'b0100);
        check({err_noise, err_frame, err_parity} == 3'b011, "R7 clear noise",
              {err_noise, err_frame, err_parity}, 3'b011);
        step(1'b0, '0, 3'b0, 1'b0, 4'b0010);
        check({err_noise, err_frame, err_parity} == 3'b001, "R7 clear frame",
              {err_noise, err_frame, err_parity}, 3'b001);
        step(1'b0, '0, 3'b0, 1'b0, 4'b0001);
        check({err_noise, err_frame, err_parity} == 3'b000, "R7 clear parity",
              {err_noise, err_frame, err_parity}, 3'b000);
        for (int j = 1; j < DEPTH; j++) push(DW'(8'h31 + j), 3'b0);
        step(1'b1, 8'hFF, 3'b0, 1'b0, 4'b1000);
        check(overrun, "R7 set wins over clear", overrun, 1);
        step(1'b0, '0, 3'b0, 1'b0, 4'b1000);
        check(!overrun, "R7 clear", overrun, 0);

        // R8: read on empty is ignored.
        do_reset(1'b1);
        step(1'b0, '0, 3'b0, 1'b1, 4'b0);
        check(!data_ready && rd_data == 0 && !overrun, "R8 empty read", rd_data, 0);
        push(8'h81, 3'b100);
        push(8'h82, 3'b0);
        pop_expect(8'h81, 3'b100, "R8 order after empty read");
        pop_expect(8'h82, 3'b000, "R8 order after empty read");

        // R9: read and arrival together on a full buffer.
        do_reset(1'b1);
        for (int j = 0; j < DEPTH; j++) push(DW'(8'h90 + j), 3'b0);
        step(1'b1, 8'h9F, 3'b001, 1'b1, 4'b0);
        check(!overrun, "R9 no overrun", overrun, 0);
        for (int j = 1; j < DEPTH; j++) pop_expect(DW'(8'h90 + j), 3'b0, "R9 order");
        pop_expect(8'h9F, 3'b001, "R9 new word stored");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule